// File: doc/BRIEF.md
# Flush and Line Dump Sequencer

This block drives the vertical transfer clocks and the two charge-drain gates of a full-frame image sensor during the two ways of discarding charge. A flush empties the whole pixel array before an exposure starts. A line dump throws away a chosen number of lines, one at a time, so that a later readout covers only part of the frame. Each drain first moves all charge under the second vertical phase. The gate is raised only while that phase is high. The gate falls before the phase does. Charge counts as gone only after a holdoff time, measured from the falling edge of the phase. The flush gate and the line-dump gate each have their own holdoff.

The readout timing generator watches `readout_hold` and stays quiet while it is high. It waits for the one-cycle `done` pulse before it moves on. A request is taken only while the sequencer is idle. If both requests arrive in the same cycle, the flush is chosen.

Top module: `flush_dump_seq`

## Requirements
- R1: A flush request in idle makes `vphase2` high with `vphase1` low from the next cycle. It stays high for SETUP_LEN cycles with both gates low, then GATE_LEN cycles with `flush_gate` high, then SETUP_LEN more cycles with both gates low. It then goes low.
- R2: A gate is high only while `vphase2` is high. `vphase2` has been high for at least one cycle before the gate rises, and the gate is already low when `vphase2` falls.
- R3: After a flush, all four drive outputs stay low for FLUSH_HOLD cycles, counted from the first cycle with `vphase2` low. `done` is then high for exactly one cycle.
- R4: Each dumped line starts with SHIFT_LEN cycles of `vphase1` high with `vphase2` low. A `vphase2` window follows, shaped as in R1, with `dump_gate` in place of `flush_gate`. `flush_gate` never rises during a dump, and `dump_gate` never rises during a flush.
- R5: Each line's `vphase2` window is followed by DUMP_HOLD cycles with all drive outputs low. A dump of N lines repeats this N times. `done` pulses once, in the cycle after the last holdoff.
- R6: A dump request with `dump_lines` equal to 0 gives a `done` pulse in the next cycle, with no drive activity.
- R7: `readout_hold` is high from the cycle after the request is accepted through the `done` cycle inclusive, and low while idle.
- R8: Requests that arrive while a sequence runs, including in its `done` cycle, have no effect. When both requests come together in idle, the flush runs.
- R9: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush_req | input | 1 | Start a whole-array flush |
| dump_req | input | 1 | Start a line dump |
| dump_lines | input | LINE_W | Number of lines to dump, sampled with `dump_req` |
| vphase1 | output | 1 | Vertical transfer phase 1 |
| vphase2 | output | 1 | Vertical transfer phase 2 |
| flush_gate | output | 1 | Whole-array drain gate |
| dump_gate | output | 1 | Single-row drain gate |
| readout_hold | output | 1 | Holds off the readout timing generator |
| done | output | 1 | One-cycle pulse when draining is complete |

## Verification
The bench compares every output on every cycle, so an off-by-one in any phase length is caught. A gate that rises in the same cycle as `vphase2`, or a holdoff timed from the wrong edge, also shows up at once. It runs dumps of 1, 3 and the full-width count of lines. A line counter that dumps one line too many or too few, or that wraps, would shift the `done` pulse. A zero-line dump must finish at once rather than run through the counter range. Requests are injected in the middle of a sequence and in its `done` cycle. A sequencer that restarted or chained on them would show extra phase activity or a second `done`. Simultaneous requests check that the flush is chosen.

// File: rtl/flush_dump_pkg.sv
// Shared state encoding for the flush and line dump sequencer.
package flush_dump_pkg;

    // Sequencer phases, in the order a line dump visits them.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_VSHIFT  = 3'd1,
        ST_V2_LEAD = 3'd2,
        ST_GATE    = 3'd3,
        ST_V2_TAIL = 3'd4,
        ST_HOLDOFF = 3'd5,
        ST_DONE    = 3'd6
    } fd_state_t;

endpackage

// File: rtl/fd_phase_timer.sv
// Phase timer: a down counter that is loaded with (length - 1) when a phase
// starts and reports zero in the last cycle of that phase.
// Assumes the controller reloads it on every phase change.
module fd_phase_timer #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          at_zero
);
    logic [CW-1:0] cnt;

    // Load a new phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign at_zero = (cnt == '0);

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val)); // R1
endmodule

// File: rtl/fd_line_counter.sv
// Line counter: keeps the number of lines still to be dumped. It is loaded when
// a dump is accepted and decremented at the end of each line's holdoff.
// Assumes it is never decremented at zero.
module fd_line_counter #(
    parameter int LINE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LINE_W-1:0] load_val,
    input  logic              dec,
    output logic              last
);
    logic [LINE_W-1:0] remaining;

    // Hold the number of lines still to be dumped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remaining <= '0;
        else if (load)
            remaining <= load_val;
        else if (dec)
            remaining <= remaining - 1'b1;
    end

    assign last = (remaining == LINE_W'(1));

    AST_LINE_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> remaining != '0); // R5
endmodule

// File: rtl/fd_ctrl_fsm.sv
// Sequencer control: steps through vertical shift, V2 lead-in, gate pulse,
// V2 tail and holdoff, and repeats per line for a dump. All drive outputs are
// decoded from the state register. Assumes every phase length is at least 1.
module fd_ctrl_fsm
    import flush_dump_pkg::*;
#(
    parameter int CW         = 14,
    parameter int SHIFT_LEN  = 800,
    parameter int SETUP_LEN  = 50,
    parameter int GATE_LEN   = 100,
    parameter int FLUSH_HOLD = 9000,
    parameter int DUMP_HOLD  = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_req,
    input  logic          dump_req,
    input  logic          dump_none,
    input  logic          tmr_zero,
    input  logic          last_line,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          cnt_load,
    output logic          cnt_dec,
    output logic          vphase1,
    output logic          vphase2,
    output logic          flush_gate,
    output logic          dump_gate,
    output logic          readout_hold,
    output logic          done
);
    localparam logic [CW-1:0] L_SHIFT = CW'(SHIFT_LEN - 1);
    localparam logic [CW-1:0] L_SETUP = CW'(SETUP_LEN - 1);
    localparam logic [CW-1:0] L_GATE  = CW'(GATE_LEN - 1);
    localparam logic [CW-1:0] L_FHOLD = CW'(FLUSH_HOLD - 1);
    localparam logic [CW-1:0] L_DHOLD = CW'(DUMP_HOLD - 1);

    fd_state_t st, st_n;
    logic      is_flush, is_flush_n;

    // Choose the next phase and the timer reload that goes with it.
    always_comb begin
        st_n       = st;
        is_flush_n = is_flush;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        cnt_load   = 1'b0;
        cnt_dec    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (flush_req) begin
                    st_n       = ST_V2_LEAD;
                    is_flush_n = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = L_SETUP;
                end else if (dump_req) begin
                    is_flush_n = 1'b0;
                    cnt_load   = 1'b1;
                    if (dump_none) begin
                        st_n = ST_DONE;
                    end else begin
                        st_n     = ST_VSHIFT;
                        tmr_load = 1'b1;
                        tmr_val  = L_SHIFT;
                    end
                end
            end
            ST_VSHIFT: if (tmr_zero) begin
                st_n     = ST_V2_LEAD;
                tmr_load = 1'b1;
                tmr_val  = L_SETUP;
            end
            ST_V2_LEAD: if (tmr_zero) begin
                st_n     = ST_GATE;
                tmr_load = 1'b1;
                tmr_val  = L_GATE;
            end
            ST_GATE: if (tmr_zero) begin
                st_n     = ST_V2_TAIL;
                tmr_load = 1'b1;
                tmr_val  = L_SETUP;
            end
            ST_V2_TAIL: if (tmr_zero) begin
                st_n     = ST_HOLDOFF;
                tmr_load = 1'b1;
                tmr_val  = is_flush ? L_FHOLD : L_DHOLD;
            end
            ST_HOLDOFF: if (tmr_zero) begin
                cnt_dec = !is_flush;
                if (!is_flush && !last_line) begin
                    st_n     = ST_VSHIFT;
                    tmr_load = 1'b1;
                    tmr_val  = L_SHIFT;
                end else begin
                    st_n = ST_DONE;
                end
            end
            ST_DONE: st_n = ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // Register the phase and the kind of sequence that is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            is_flush <= 1'b0;
        end else begin
            st       <= st_n;
            is_flush <= is_flush_n;
        end
    end

    // Decode the drive pins from the state register.
    always_comb begin
        vphase1      = (st == ST_VSHIFT);
        vphase2      = (st == ST_V2_LEAD) || (st == ST_GATE) || (st == ST_V2_TAIL);
        flush_gate   = (st == ST_GATE) && is_flush;
        dump_gate    = (st == ST_GATE) && !is_flush;
        readout_hold = (st != ST_IDLE);
        done         = (st == ST_DONE);
    end

    AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && flush_req) |=> (st == ST_V2_LEAD && is_flush)); // R8
    AST_BUSY_KEEPS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> is_flush == $past(is_flush)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
endmodule

// File: rtl/flush_dump_seq.sv
// Flush and line dump sequencer, top level. It drives the vertical phases and
// the two drain gates for a whole-array flush or an N-line dump, and holds off
// readout until the final holdoff has elapsed. Phase lengths are in clock cycles.
module flush_dump_seq #(
    parameter int LINE_W     = 13,
    parameter int SHIFT_LEN  = 800,
    parameter int SETUP_LEN  = 50,
    parameter int GATE_LEN   = 100,
    parameter int FLUSH_HOLD = 9000,
    parameter int DUMP_HOLD  = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_req,
    input  logic              dump_req,
    input  logic [LINE_W-1:0] dump_lines,
    output logic              vphase1,
    output logic              vphase2,
    output logic              flush_gate,
    output logic              dump_gate,
    output logic              readout_hold,
    output logic              done
);
    localparam int M1     = (SHIFT_LEN > SETUP_LEN) ? SHIFT_LEN : SETUP_LEN;
    localparam int M2     = (GATE_LEN > M1) ? GATE_LEN : M1;
    localparam int M3     = (FLUSH_HOLD > M2) ? FLUSH_HOLD : M2;
    localparam int MAXLEN = (DUMP_HOLD > M3) ? DUMP_HOLD : M3;
    localparam int CW     = (MAXLEN < 2) ? 1 : $clog2(MAXLEN);

    logic          tmr_load, tmr_zero, cnt_load, cnt_dec, last_line;
    logic [CW-1:0] tmr_val;

    fd_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .at_zero(tmr_zero)
    );

    fd_line_counter #(.LINE_W(LINE_W)) u_lines (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(dump_lines),
        .dec(cnt_dec), .last(last_line)
    );

    fd_ctrl_fsm #(
        .CW(CW), .SHIFT_LEN(SHIFT_LEN), .SETUP_LEN(SETUP_LEN), .GATE_LEN(GATE_LEN),
        .FLUSH_HOLD(FLUSH_HOLD), .DUMP_HOLD(DUMP_HOLD)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .dump_req(dump_req),
        .dump_none(dump_lines == '0), .tmr_zero(tmr_zero), .last_line(last_line),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .cnt_load(cnt_load), .cnt_dec(cnt_dec),
        .vphase1(vphase1), .vphase2(vphase2), .flush_gate(flush_gate),
        .dump_gate(dump_gate), .readout_hold(readout_hold), .done(done)
    );

    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(vphase1 && vphase2)); // R1
    AST_GATE_AFTER_V2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_gate || dump_gate) |-> $past(vphase2)); // R2
    AST_V2_FALL_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vphase2) |-> $past(!flush_gate && !dump_gate)); // R2
    AST_GATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_gate && dump_gate)); // R4
    AST_DONE_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> readout_hold && !vphase1 && !vphase2); // R7
endmodule

// File: tb/tb_flush_dump_seq.sv
// Scoreboard bench: driver tasks push the expected output word for every cycle
// of a sequence; a monitor pops and compares one word per cycle.
module tb_flush_dump_seq;
    localparam int LW = 8, SH = 3, SU = 2, GT = 4, FH = 30, DH = 10;

    logic clk = 1'b0, rst_n = 1'b0, flush_req = 1'b0, dump_req = 1'b0;
    logic [LW-1:0] dump_lines = '0;
    logic vphase1, vphase2, flush_gate, dump_gate, readout_hold, done;

    flush_dump_seq #(.LINE_W(LW), .SHIFT_LEN(SH), .SETUP_LEN(SU), .GATE_LEN(GT),
                     .FLUSH_HOLD(FH), .DUMP_HOLD(DH)) dut (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .dump_req(dump_req),
        .dump_lines(dump_lines), .vphase1(vphase1), .vphase2(vphase2),
        .flush_gate(flush_gate), .dump_gate(dump_gate),
        .readout_hold(readout_hold), .done(done)
    );

    always #10 clk = ~clk;   // 50 MHz

    int    vectors = 0, miscompares = 0;
    bit    finished = 1'b0;
    string idle_tag = "R7";
    logic [5:0] exp_q[$];
    string      tag_q[$];

    function automatic logic [5:0] actual();
        return {vphase1, vphase2, flush_gate, dump_gate, readout_hold, done};
    endfunction

    task automatic check(input logic [5:0] act, input logic [5:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: outputs {v1,v2,fg,dg,hold,done} = %b, expected %b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    task automatic push_n(input logic [5:0] v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v);
            tag_q.push_back(tag);
        end
    endtask

    task automatic push_flush();
        push_n(6'b010010, SU, "R1");
        push_n(6'b011010, GT, "R1");
        push_n(6'b010010, SU, "R2");
        push_n(6'b000010, FH, "R3");
        push_n(6'b000011, 1, "R3");
    endtask

    task automatic push_dump(input int n);
        if (n == 0) push_n(6'b000011, 1, "R6");
        for (int l = 0; l < n; l++) begin
            push_n(6'b100010, SH, "R4");
            push_n(6'b010010, SU, "R4");
            push_n(6'b010110, GT, "R4");
            push_n(6'b010010, SU, "R2");
            push_n(6'b000010, DH, "R5");
        end
        if (n != 0) push_n(6'b000011, 1, "R5");
    endtask

    // Drive a one-cycle request and queue its expected response.
    task automatic launch(input bit f, input bit d, input int n);
        @(negedge clk);
        flush_req = f; dump_req = d; dump_lines = LW'(n);
        if (f) push_flush();
        else if (d) push_dump(n);
        @(negedge clk);
        flush_req = 1'b0; dump_req = 1'b0;
    endtask

    // Pulse requests while busy; nothing is queued since they must be ignored.
    task automatic poke(input bit f, input bit d, input int n, input int later);
        repeat (later) @(negedge clk);
        flush_req = f; dump_req = d; dump_lines = LW'(n);
        @(negedge clk);
        flush_req = 1'b0; dump_req = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // Monitor: compare one expected word per cycle, idle zeros when empty.
    initial begin
        wait (rst_n === 1'b1);
        forever begin
            logic [5:0] e;
            string t;
            @(posedge clk);
            #5;
            if (exp_q.size() != 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
            end else begin
                e = '0;
                t = idle_tag;
            end
            check(actual(), e, t);
        end
    end

    // Watchdog.
    initial begin
        #(20 * 150000);
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual hung, expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(actual(), 6'b000000, "R9 reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        launch(1'b1, 1'b0, 0);        // R1 R3 flush
        drain();
        launch(1'b0, 1'b1, 1);        // R4 R5 single line
        drain();
        launch(1'b0, 1'b1, 3);        // R5 three lines
        drain();
        launch(1'b0, 1'b1, 0);        // R6 zero lines
        drain();

        idle_tag = "R8 ignore";
        launch(1'b1, 1'b0, 0);        // R8 dump during flush
        poke(1'b0, 1'b1, 2, 5);
        poke(1'b1, 1'b0, 0, 10);
        drain();
        launch(1'b0, 1'b1, 2);        // R8 flush during dump
        poke(1'b1, 1'b0, 0, 4);
        poke(1'b0, 1'b1, 5, 20);
        drain();
        launch(1'b1, 1'b1, 4);        // R8 simultaneous: flush wins
        drain();

        launch(1'b0, 1'b1, 1);        // R8 request in the done cycle
        @(negedge clk);
        while (done !== 1'b1) @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        drain();
        check({5'b0, readout_hold}, 6'b0, "R7 idle after done");

        idle_tag = "R7";
        launch(1'b0, 1'b1, 255);      // R5 full-width count
        drain();
        summary();
    end
endmodule